// File: doc/BRIEF.md
# PC Card Bus Cycle Timing Generator

This block turns one host request into a single PC Card bus access, timed entirely in whole periods of the host clock. When it accepts a request, it drives the card address and holds it for a setup interval. It then pulls the active-low command strobe low for a command interval and keeps the address stable for a short hold interval. Finally it raises a one-clock completion pulse.

The lengths of the setup and command intervals come from a fixed lookup. The lookup is keyed on four things: the kind of access (I/O or memory), the data width (8 or 16 bit), the window's 2-bit wait-state field and its zero-wait-state bit. Every length is a little longer than the legacy controller timing that existing software expects. One combination has no timing of its own: a 16-bit I/O access with no wait state and zero-wait-state requested. The block runs it with the ordinary 16-bit I/O timing and latches an error flag.

Top module: `pccard_cycle_gen`

## Requirements
- R1: After a synchronous active-high reset, the block is idle: `cmd_n` is 1, and `busy`, `done` and `cfg_err` are 0.
- R2: Setup is the number of clocks `busy` is high before `cmd_n` falls. It is 3 clocks for every I/O access (`is_mem`=0). For a memory access it is 2 clocks when `ws[1]`=0 and 4 clocks when `ws[1]`=1.
- R3: For 8-bit accesses (`is_16`=0), the command interval (clocks with `cmd_n`=0) is as follows. For I/O it is 23 when `ws[0]`=1, 7 when `ws[0]`=0 with `zws`=1, and otherwise 19. For memory it is 23 when `ws`!=0, 7 when `ws`=0 with `zws`=1, and otherwise 19.
- R4: For 16-bit memory accesses, the command interval is 9, 13, 17 or 21 clocks for `ws` = 0, 1, 2 or 3, except 5 clocks when `ws`=0 with `zws`=1. For 16-bit I/O it is 11 clocks when `ws[0]`=1 and 7 clocks when `ws[0]`=0.
- R5: After `cmd_n` rises, `busy` stays high for exactly 2 more clocks. In the next clock `busy` is 0 and `done` is 1, for exactly one clock.
- R6: `cmd_n` is 1 whenever it is not in the command interval, including all of setup and hold. `card_addr` equals the accepted address and does not change while `busy` is high.
- R7: `req` and the other request inputs are ignored while `busy` or `done` is high. A request pulsed during an access changes neither its address nor its timing, and starts no second access.
- R8: Accepting a 16-bit I/O request with `ws[0]`=0 and `zws`=1 sets `cfg_err`, and `cfg_err` stays set until reset. No other request sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, all timing is counted on it |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, sampled only while idle |
| is_mem | input | 1 | 1 = memory access, 0 = I/O access |
| is_16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| ws | input | 2 | Window wait-state field |
| zws | input | 1 | Window zero-wait-state bit |
| addr_in | input | ADDR_W | Card address of the request |
| card_addr | output | ADDR_W | Address driven to the card |
| cmd_n | output | 1 | Active-low command strobe |
| busy | output | 1 | High from the first setup clock to the last hold clock |
| done | output | 1 | One-clock completion pulse |
| cfg_err | output | 1 | Sticky flag for the unsupported 16-bit I/O combination |

## Verification
The bench sweeps every row of the lookup, each with a different address. This exposes a design that picks the wrong wait-state bit for I/O or lets `zws` shorten a cycle that has wait states: such a design would measure a 7- or 19-clock strobe where 23 or 11 is due. It also checks the hold edge. An off-by-one counter there would show as a hold of 1 or 3 clocks, or as `done` overlapping `busy`. A request pulsed in the middle of an access catches a design that re-latches inputs outside idle: the address would change mid-access or a second access would follow. The unsupported 16-bit I/O combination is issued and then followed by a clean access, to show that the flag sets and then stays set.

// File: rtl/pccard_cycle_gen.sv
module pccard_cycle_gen #(
  parameter int ADDR_W    = 26,
  parameter int HOLD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_mem,
  input  logic              is_16,
  input  logic [1:0]        ws,
  input  logic              zws,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] card_addr,
  output logic              cmd_n,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);

  localparam int CNT_W = 5;

  localparam logic [CNT_W-1:0] SU_IO    = CNT_W'(3);
  localparam logic [CNT_W-1:0] SU_MEM_S = CNT_W'(2);
  localparam logic [CNT_W-1:0] SU_MEM_L = CNT_W'(4);
  localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_HOLD, S_DONE} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmd_len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  setup_len;
  logic [CNT_W-1:0]  cmd_len;
  logic              bad_combo;
  logic              cnt_end;

  // setup length lookup
  assign setup_len = !is_mem ? SU_IO : (ws[1] ? SU_MEM_L : SU_MEM_S);

  // command length lookup
  always_comb begin
    cmd_len = CNT_W'(19);
    unique case ({is_16, is_mem})
      2'b00: cmd_len = ws[0] ? CNT_W'(23) : (zws ? CNT_W'(7) : CNT_W'(19));
      2'b01: cmd_len = (ws != 2'd0) ? CNT_W'(23) : (zws ? CNT_W'(7) : CNT_W'(19));
      2'b10: cmd_len = ws[0] ? CNT_W'(11) : CNT_W'(7);
      2'b11: cmd_len = (ws == 2'd0 && zws) ? CNT_W'(5)
                                            : CNT_W'(9) + CNT_W'({ws, 2'b00});
      default: cmd_len = CNT_W'(19);
    endcase
  end

  assign bad_combo = is_16 && !is_mem && !ws[0] && zws;
  assign cnt_end   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      cmd_len_q <= '0;
      addr_q    <= '0;
      cfg_err   <= 1'b0;
    end else begin
      unique case (phase)
        S_IDLE: if (req) begin
          addr_q    <= addr_in;
          cnt       <= setup_len - CNT_W'(1);
          cmd_len_q <= cmd_len;
          phase     <= S_SETUP;
          if (bad_combo) cfg_err <= 1'b1;
        end
        S_SETUP: if (cnt_end) begin
          cnt   <= cmd_len_q - CNT_W'(1);
          phase <= S_CMD;
        end else cnt <= cnt - CNT_W'(1);
        S_CMD: if (cnt_end) begin
          cnt   <= HOLD_M1;
          phase <= S_HOLD;
        end else cnt <= cnt - CNT_W'(1);
        S_HOLD: if (cnt_end) phase <= S_DONE;
                else cnt <= cnt - CNT_W'(1);
        S_DONE: phase <= S_IDLE;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign card_addr = addr_q;
  assign cmd_n     = (phase != S_CMD);
  assign busy      = (phase == S_SETUP) || (phase == S_CMD) || (phase == S_HOLD);
  assign done      = (phase == S_DONE);

  // assertions
  p_strobe_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmd_n);

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(card_addr));

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  p_req_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_len_q));

endmodule

// File: tb/pccard_cycle_gen_tb_top.sv
module pccard_cycle_gen_tb_top;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, is_mem = 1'b0, is_16 = 1'b0, zws = 1'b0;
  logic [1:0] ws = 2'd0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] card_addr;
  logic cmd_n, busy, done, cfg_err;

  always #4 clk = ~clk;

  pccard_cycle_gen #(.ADDR_W(AW), .HOLD_CLKS(2)) dut_i (
    .clk(clk), .rst(rst), .req(req), .is_mem(is_mem), .is_16(is_16),
    .ws(ws), .zws(zws), .addr_in(addr_in), .card_addr(card_addr),
    .cmd_n(cmd_n), .busy(busy), .done(done), .cfg_err(cfg_err));

  typedef struct {
    int su; int cm; int ho; logic [AW-1:0] a; string tag;
  } exp_t;

  exp_t sb[$];
  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int su_of(bit m, logic [1:0] w);
    if (!m) return 3;
    return w[1] ? 4 : 2;
  endfunction

  function automatic int cm_of(bit m, bit b16, logic [1:0] w, bit z);
    if (!b16 && !m) return w[0] ? 23 : (z ? 7 : 19);
    if (!b16 &&  m) return (w != 0) ? 23 : (z ? 7 : 19);
    if ( b16 && !m) return w[0] ? 11 : 7;
    if (w == 0 && z) return 5;
    case (w) 2'd0: return 9; 2'd1: return 13; 2'd2: return 17; default: return 21; endcase
  endfunction

  // monitor: measure each access at the falling edge
  int ph = 0, c_su = 0, c_cm = 0, c_ho = 0;
  logic [AW-1:0] a0;
  bit a_ok = 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) begin
        if (ph == 0) begin ph = 1; c_su = 0; c_cm = 0; c_ho = 0; a0 = card_addr; a_ok = 1; end
        if (card_addr !== a0) a_ok = 0;
        if (!cmd_n) begin ph = 2; c_cm++; end
        else if (ph == 1) c_su++;
        else c_ho++;
      end
      if (done) begin
        if (sb.size() == 0) chk(0, "R7 unexpected access", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(c_su == e.su, {"R2 setup ", e.tag}, c_su, e.su);
          chk(c_cm == e.cm, {"R3/R4 cmd ", e.tag}, c_cm, e.cm);
          chk(c_ho == e.ho, {"R5 hold ", e.tag}, c_ho, e.ho);
          chk(a_ok && (a0 == e.a), {"R6 addr ", e.tag}, int'(a0), int'(e.a));
          chk(!busy, "R5 busy low with done", busy, 0);
        end
        ph = 0;
      end
    end
  end

  task automatic run(input bit m, input bit b16, input logic [1:0] w, input bit z,
                     input logic [AW-1:0] a, input string tag, input bit poke);
    exp_t e;
    e.su = su_of(m, w); e.cm = cm_of(m, b16, w, z); e.ho = 2; e.a = a; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    is_mem = m; is_16 = b16; ws = w; zws = z; addr_in = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      is_mem = ~m; is_16 = ~b16; ws = ~w; zws = ~z; addr_in = ~a; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_n && !busy && !done && !cfg_err, "R1 reset state",
        {cmd_n, busy, done, cfg_err}, 4'b1000);

    // 8-bit I/O
    run(0, 0, 2'd0, 0, 26'h0000101, "R3 io8 ws0", 0);
    run(0, 0, 2'd1, 1, 26'h0000102, "R3 io8 ws1 zws", 0);
    run(0, 0, 2'd0, 1, 26'h0000103, "R3 io8 zws", 0);
    // 8-bit memory
    for (int w = 0; w < 4; w++)
      run(1, 0, 2'(w), 1, 26'h1000000 + AW'(w), "R3 mem8 zws", 0);
    run(1, 0, 2'd0, 0, 26'h1000010, "R3 mem8 ws0", 0);
    // 16-bit memory
    for (int w = 0; w < 4; w++)
      run(1, 1, 2'(w), 0, 26'h2000000 + AW'(w), "R4 mem16", 0);
    run(1, 1, 2'd0, 1, 26'h2000010, "R4 mem16 zws", 0);
    run(1, 1, 2'd2, 1, 26'h2000011, "R4 mem16 ws2 zws", 0);
    // 16-bit I/O
    run(0, 1, 2'd0, 0, 26'h3000001, "R4 io16 ws0", 0);
    run(0, 1, 2'd1, 0, 26'h3000002, "R4 io16 ws1", 0);
    chk(!cfg_err, "R8 no error on legal requests", cfg_err, 0);

    // R7: request pulsed mid-access is ignored
    run(1, 0, 2'd1, 0, 26'h0ABCDEF, "R7 poke", 1);
    repeat (6) @(negedge clk);
    chk(!busy && sb.size() == 0, "R7 no second access", busy, 0);

    // R8: unsupported combo falls back, flag sticks
    run(0, 1, 2'd0, 1, 26'h3000003, "R8 io16 zws", 0);
    chk(cfg_err, "R8 error set", cfg_err, 1);
    run(1, 1, 2'd3, 0, 26'h3000004, "R8 after error", 0);
    chk(cfg_err, "R8 error sticky", cfg_err, 1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cfg_err && cmd_n && !busy, "R1 reset clears error", cfg_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule